// File: doc/BRIEF.md
# Pointer-Redirected Data Register File

This block is a small byte-wide data register file in which one address has no storage of its own. Any access to that virtual address goes to the register named by a pointer register. The pointer is itself an ordinary register in the file. Software loads it directly, then reads or writes through the virtual address. Stepping the pointer lets a loop walk through consecutive locations, for example to clear a buffer.

The core supplies one direct address per cycle, together with a write enable and write data. Read data is combinational from the address. A write commits on the rising clock edge and is visible to the next access. A bank input is concatenated above the pointer to form a wider effective address. With the default configuration that bank bit is ignored.

Two self-references are handled specially. When the pointer holds the virtual address, an indirect read returns zero and an indirect write changes nothing. When the pointer holds the pointer's own address, indirect accesses reach the pointer register.

Top module: `ptr_regfile`

## Requirements
- R1: After a synchronous reset the pointer register (direct address 4h) reads 00h.
- R2: A direct write to any address other than 0h and 4h stores the data. A direct read of that address returns it in the same cycle, and the stored value is available from the cycle after the write.
- R3: A direct write to address 4h replaces the pointer. The very next access, direct or through address 0h, uses the new pointer value.
- R4: A read of address 0h returns the contents of the register whose address is in the pointer, when the pointer is neither 0h nor 4h.
- R5: A write to address 0h stores the data into the register addressed by the pointer and into no other location.
- R6: While the pointer holds 0h, a read of address 0h returns 00h.
- R7: While the pointer holds 0h, a write to address 0h has no effect: the pointer and every stored location keep their values.
- R8: With the default configuration the bank input does not change which register an access through address 0h reaches.
- R9: Incrementing the pointer and then accessing address 0h reaches the next location. A loop that starts at 20h and steps until pointer bit 4 is set clears exactly 20h to 2Fh.
- R10: While the pointer holds 4h, a read of address 0h returns the pointer value, and a write to address 0h replaces the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the pointer |
| addr | input | W (8) | Direct address from the core |
| bankSel | input | 1 | Bank bit placed above the pointer in the effective address |
| wrEn | input | 1 | Write strobe, committed on the rising edge |
| wrData | input | W (8) | Data to write |
| rdData | output | W (8) | Combinational read data for the current address |

## Verification
Read data is due in the same cycle as the address that selects it. The bench drives each access just after a falling edge and samples `rdData` 1 ns later, before the next rising edge. Any write, including a pointer update, lands on the following rising edge. Each write is therefore folded into the bench model only after that edge, and the next access is checked against the updated model. A seeded random run mixes direct, pointer and indirect accesses, including the two self-reference cases, with directed corner cases.

// File: rtl/ptr_regfile_pkg.sv
package ptr_regfile_pkg;

  // Strobes from the decode/control side to the datapath.
  typedef struct packed {
    logic isVirt;   // access aimed at the virtual address
    logic selfRef;  // indirect access whose pointer names the virtual address
    logic hitPtr;   // resolved target is the pointer register
    logic memWr;    // commit write into storage
    logic ptrWr;    // commit write into the pointer
  } accStrobes_t;

endpackage

// File: rtl/ptr_regfile_ctrl.sv
module ptr_regfile_ctrl
  import ptr_regfile_pkg::*;
#(
  parameter int W         = 8,
  parameter int VIRT_ADDR = 0,
  parameter int PTR_ADDR  = 4,
  parameter int USE_BANK  = 0,
  parameter int IDX_W     = W + USE_BANK
) (
  input  logic [W-1:0]     addr,
  input  logic             bankSel,
  input  logic             wrEn,
  input  logic [W-1:0]     fsrVal,
  output accStrobes_t      strb,
  output logic [IDX_W-1:0] tgtIdx
);

  localparam logic [W-1:0] VIRT = W'(VIRT_ADDR);
  localparam logic [W-1:0] PTR  = W'(PTR_ADDR);

  logic         isVirt;
  logic [W-1:0] tgtLow;
  logic         selfRef;
  logic         hitPtr;

  assign isVirt  = (addr == VIRT);
  assign tgtLow  = isVirt ? fsrVal : addr;
  assign selfRef = isVirt && (tgtLow == VIRT);
  assign hitPtr  = !selfRef && (tgtLow == PTR);

  generate
    if (USE_BANK != 0) begin : g_bank
      assign tgtIdx = isVirt ? {bankSel, fsrVal} : {1'b0, addr};
    end else begin : g_noBank
      logic unusedBank;
      assign unusedBank = bankSel;
      assign tgtIdx     = tgtLow;
    end
  endgenerate

  always_comb begin
    strb.isVirt  = isVirt;
    strb.selfRef = selfRef;
    strb.hitPtr  = hitPtr;
    strb.ptrWr   = wrEn && hitPtr;
    strb.memWr   = wrEn && !selfRef && !hitPtr;
  end

endmodule

// File: rtl/ptr_regfile_dpath.sv
module ptr_regfile_dpath
  import ptr_regfile_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  accStrobes_t      strb,
  input  logic [IDX_W-1:0] tgtIdx,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     fsrQ,
  output logic [W-1:0]     rdData
);

  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0] mem [DEPTH];
  logic         unusedVirt;

  assign unusedVirt = strb.isVirt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fsrQ <= '0;
    end else if (strb.ptrWr) begin
      fsrQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.memWr) begin
      mem[tgtIdx] <= wrData;
    end
  end

  always_comb begin
    if (strb.selfRef) begin
      rdData = '0;
    end else if (strb.hitPtr) begin
      rdData = fsrQ;
    end else begin
      rdData = mem[tgtIdx];
    end
  end

endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_regfile_pkg::*;
#(
  parameter int W         = 8,
  parameter int VIRT_ADDR = 0,
  parameter int PTR_ADDR  = 4,
  parameter int USE_BANK  = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] addr,
  input  logic         bankSel,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData
);

  localparam int IDX_W = W + USE_BANK;

  accStrobes_t      strb;
  logic [IDX_W-1:0] tgtIdx;
  logic [W-1:0]     fsrQ;

  ptr_regfile_ctrl #(
    .W(W), .VIRT_ADDR(VIRT_ADDR), .PTR_ADDR(PTR_ADDR),
    .USE_BANK(USE_BANK), .IDX_W(IDX_W)
  ) u_ctrl (
    .addr(addr), .bankSel(bankSel), .wrEn(wrEn),
    .fsrVal(fsrQ), .strb(strb), .tgtIdx(tgtIdx)
  );

  ptr_regfile_dpath #(
    .W(W), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .tgtIdx(tgtIdx),
    .wrData(wrData), .fsrQ(fsrQ), .rdData(rdData)
  );

endmodule

// File: rtl/ptr_regfile_chk.sv
module ptr_regfile_chk #(
  parameter int W         = 8,
  parameter int VIRT_ADDR = 0,
  parameter int PTR_ADDR  = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] addr,
  input logic         bankSel,
  input logic         wrEn,
  input logic [W-1:0] wrData,
  input logic [W-1:0] rdData,
  input logic [W-1:0] fsrQ
);

  localparam logic [W-1:0] VIRT = W'(VIRT_ADDR);
  localparam logic [W-1:0] PTR  = W'(PTR_ADDR);

  logic rstD;

  always_ff @(posedge clk) begin
    rstD <= rst;
    if (rstD) begin
      p_ptr_cleared_r1: assert (fsrQ == '0)
        else $error("pointer not cleared by reset");
    end
  end

  p_direct_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr != VIRT && addr != PTR) ##1 (addr == $past(addr))
      |-> rdData == $past(wrData));

  p_ptr_load_r3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == PTR) |=> fsrQ == $past(wrData));

  p_indirect_store_r5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == VIRT && fsrQ != VIRT && fsrQ != PTR)
      ##1 (addr == VIRT && fsrQ == $past(fsrQ) && bankSel == $past(bankSel))
      |-> rdData == $past(wrData));

  p_self_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (addr == VIRT && fsrQ == VIRT) |-> rdData == '0);

  p_self_write_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == VIRT && fsrQ == VIRT) |=> fsrQ == VIRT);

  p_indirect_ptr_read_r10: assert property (@(posedge clk) disable iff (rst)
    (addr == VIRT && fsrQ == PTR) |-> rdData == fsrQ);

endmodule

bind ptr_regfile ptr_regfile_chk #(
  .W(W), .VIRT_ADDR(VIRT_ADDR), .PTR_ADDR(PTR_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .bankSel(bankSel), .wrEn(wrEn),
  .wrData(wrData), .rdData(rdData), .fsrQ(fsrQ)
);

// File: tb/test_ptr_regfile.sv
`timescale 1ns/1ps
module test_ptr_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       bankSel = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0] mdl [256];
  logic [7:0] fsrM;

  always #4 clk = ~clk;

  ptr_regfile i_ptr_regfile (
    .clk(clk), .rst(rst), .addr(addr), .bankSel(bankSel),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] expRd(input logic [7:0] a);
    logic [7:0] t;
    if (a == 8'h00 && fsrM == 8'h00) return 8'h00;
    t = (a == 8'h00) ? fsrM : a;
    if (t == 8'h04) return fsrM;
    return mdl[t];
  endfunction

  function automatic void mdlWrite(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] t;
    if (a == 8'h00 && fsrM == 8'h00) return;
    t = (a == 8'h00) ? fsrM : a;
    if (t == 8'h04) fsrM = d;
    else mdl[t] = d;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One access: drive after falling edge, sample read 1 ns later, commit at rising edge.
  task automatic acc(input logic [7:0] a, input logic w, input logic [7:0] d,
                     input logic b, output logic [7:0] r);
    @(negedge clk);
    addr = a; wrEn = w; wrData = d; bankSel = b;
    #1 r = rdData;
    @(posedge clk);
    #1 wrEn = 1'b0;
    if (w) mdlWrite(a, d);
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic b);
    logic [7:0] e;
    logic [7:0] r;
    e = expRd(a);
    acc(a, 1'b0, 8'h00, b, r);
    chk(req, r, e);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] r;
    acc(a, 1'b1, d, 1'b0, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [7:0] v;
    fsrM = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: pointer clear after reset
    rdChk("R1", 8'h04, 1'b0);
    rdChk("R6", 8'h00, 1'b0);

    // Initialise ordinary storage
    for (int a = 8; a < 256; a++) wr(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 1; a < 4; a++)   wr(8'(a), 8'(a) ^ 8'hA5);
    for (int a = 5; a < 8; a++)   wr(8'(a), 8'(a) ^ 8'hA5);

    // R2: direct stores, same-cycle read
    wr(8'h40, 8'h3C); rdChk("R2", 8'h40, 1'b0);
    wr(8'hFF, 8'h81); rdChk("R2", 8'hFF, 1'b0);
    rdChk("R2", 8'h01, 1'b0);

    // R3 and R4: pointer load takes effect on the very next access
    wr(8'h04, 8'h40); rdChk("R3", 8'h04, 1'b0);
    rdChk("R4", 8'h00, 1'b0);
    wr(8'h04, 8'h9B); rdChk("R3", 8'h00, 1'b0);

    // R5: indirect store hits only its target
    wr(8'h04, 8'h33); wr(8'h00, 8'hC3);
    rdChk("R5", 8'h33, 1'b0);
    rdChk("R5", 8'h32, 1'b0);
    rdChk("R5", 8'h34, 1'b0);

    // R6 and R7: self reference
    wr(8'h04, 8'h00); rdChk("R6", 8'h00, 1'b0);
    wr(8'h00, 8'hFF);
    rdChk("R7", 8'h04, 1'b0);
    rdChk("R7", 8'h00, 1'b0);
    for (int a = 1; a < 16; a++) if (a != 4) rdChk("R7", 8'(a), 1'b0);
    rdChk("R7", 8'hFF, 1'b0);

    // R8: bank bit ignored
    wr(8'h04, 8'h77);
    rdChk("R8", 8'h00, 1'b1);
    acc(8'h00, 1'b1, 8'h5D, 1'b1, r);
    rdChk("R8", 8'h77, 1'b0);
    rdChk("R8", 8'h00, 1'b0);

    // R10: pointer pointing at itself
    wr(8'h04, 8'h04); rdChk("R10", 8'h00, 1'b0);
    wr(8'h00, 8'h21); rdChk("R10", 8'h04, 1'b0);

    // R9: clear 20h..2Fh by walking the pointer until bit 4 is set
    wr(8'h2F, 8'hEE); wr(8'h30, 8'hEF); wr(8'h1F, 8'hED);
    wr(8'h04, 8'h20);
    v = 8'h20;
    while (v[4] == 1'b0) begin
      wr(8'h00, 8'h00);
      acc(8'h04, 1'b0, 8'h00, 1'b0, r);
      wr(8'h04, r + 8'h01);
      v = r + 8'h01;
    end
    chk("R9", v, 8'h30);
    for (int a = 8'h20; a < 8'h30; a++) begin
      acc(8'(a), 1'b0, 8'h00, 1'b0, r);
      chk("R9", r, 8'h00);
    end
    rdChk("R9", 8'h30, 1'b0);
    rdChk("R9", 8'h1F, 1'b0);

    // Random mix of direct, pointer and indirect accesses
    void'($urandom(32'h0C0FFEE5));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [7:0] e;
      logic       w;
      case ($urandom % 4)
        0: a = 8'h00;
        1: a = 8'h04;
        default: a = 8'($urandom);
      endcase
      w = 1'($urandom);
      v = ($urandom % 8 == 0) ? 8'h00 : 8'($urandom);
      e = expRd(a);
      acc(a, w, v, 1'($urandom), r);
      if (a == 8'h00 && e == 8'h00 && fsrM == 8'h00) chk("R6", r, e);
      else if (a == 8'h00) chk("R4", r, e);
      else if (a == 8'h04) chk("R3", r, e);
      else chk("R2", r, e);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule